// File: doc/BRIEF.md
# Eight-Bit Accumulator Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit that works on an 8-bit accumulator operand and an 8-bit data operand. A 4-bit function select picks one of ten operations: pass-through of the data operand, add, subtract, bitwise AND, bitwise OR, complement, increment, and three single-place shifts of the accumulator operand. The shifts are logical right, logical left and arithmetic right.

The block produces an 8-bit result together with a carry flag and a zero flag. Each operation has its own carry rule. Add reports its carry out, subtract reports its borrow, and complement forces carry high. The shifts report the bit that was shifted out. Every other operation drives carry low, so the outputs are always defined. The zero flag follows the result for every select value. Select codes 10 to 15 are unused and give a zero result with carry low. A surrounding datapath registers the result and writes it back to the accumulator; this block holds no state.

Top module: `acc_alu`

## Requirements
- R1: Select code 0 passes the data operand to the result unchanged and drives carry to 0.
- R2: Select code 1 sets the result to the 8-bit sum of the accumulator and data operands. Carry is the ninth bit of that sum.
- R3: Select code 2 sets the result to the accumulator minus data, modulo 256. Carry is 1 exactly when data is greater than the accumulator (borrow).
- R4: Select code 3 gives the bitwise AND of the two operands and select code 4 gives their bitwise OR. Both drive carry to 0.
- R5: Select code 5 gives the bitwise inversion of the accumulator operand, with carry forced to 1.
- R6: Select code 6 gives the accumulator plus one, modulo 256. Carry is 0, including when the value wraps from 0xFF to 0x00.
- R7: Select code 7 shifts the accumulator right by one place. A 0 enters bit 7, and the old bit 0 goes to carry.
- R8: Select code 8 shifts the accumulator left by one place. A 0 enters bit 0, and the old bit 7 goes to carry.
- R9: Select code 9 shifts the accumulator right by one place, keeping bit 7 at its old value. The old bit 0 goes to carry.
- R10: For every select code, the zero flag is 1 exactly when the 8-bit result is 0x00.
- R11: Select codes 10 to 15 give a result of 0x00, carry 0 and zero flag 1, for any operand values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_in | input | 8 | Accumulator operand |
| opd_in | input | 8 | Data operand |
| op_sel | input | 4 | Function select code |
| res_out | output | 8 | Operation result |
| carry_out | output | 1 | Carry, borrow or shifted-out bit, per operation |
| zero_out | output | 1 | High when the result is zero |

## Verification
The two flags can be raised by the same operation in the same evaluation. The bench provokes this with operands that land the result exactly on zero while the carry rule also fires: 0x80 plus 0x80, a right shift of 0x01, and a left shift of 0x80. Each of these must show both flags high. Increment of 0xFF is the counter case: it wraps to zero but must leave carry low. The scoreboard judges each flag separately against its own requirement.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned OP_COUNT = 10;

  typedef enum logic [SEL_W-1:0] {
    OP_PASS = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_INV  = 4'd5,
    OP_INC  = 4'd6,
    OP_SHR  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SAR  = 4'd9
  } op_e;

  function automatic logic sel_is_used(input logic [SEL_W-1:0] s);
    return (32'(s) < OP_COUNT);
  endfunction
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] add_res_o,
  output logic         add_cy_o,
  output logic [W-1:0] sub_res_o,
  output logic         sub_bw_o,
  output logic [W-1:0] inc_res_o
);
  localparam int unsigned EW = W + 1;

  // Full adder over W bits with carry-in, extended result.
  function automatic logic [EW-1:0] add_ext(input logic [W-1:0] x,
                                            input logic [W-1:0] y,
                                            input logic cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  logic [EW-1:0] sum_w, dif_w, inc_w;

  always_comb begin
    sum_w = add_ext(a_i, b_i, 1'b0);
    dif_w = add_ext(a_i, ~b_i, 1'b1);   // two's complement subtract
    inc_w = add_ext(a_i, '0, 1'b1);
  end

  assign add_res_o = sum_w[W-1:0];
  assign add_cy_o  = sum_w[W];
  assign sub_res_o = dif_w[W-1:0];
  assign sub_bw_o  = ~dif_w[W];         // no carry out means a borrow
  assign inc_res_o = inc_w[W-1:0];

  always_comb begin
    p_add_carry_r2: assert (add_cy_o == (add_res_o < a_i))
      else $error("R2 carry does not match wrap of sum");
    p_sub_borrow_r3: assert (sub_bw_o == (sub_res_o > a_i))
      else $error("R3 borrow does not match wrap of difference");
    p_inc_step_r6: assert ((inc_res_o == '0) == (&a_i))
      else $error("R6 increment wrap mismatch");
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] inv_o
);
  function automatic logic [W-1:0] bit_and(input logic [W-1:0] x, input logic [W-1:0] y);
    return x & y;
  endfunction

  function automatic logic [W-1:0] bit_or(input logic [W-1:0] x, input logic [W-1:0] y);
    return x | y;
  endfunction

  function automatic logic [W-1:0] bit_inv(input logic [W-1:0] x);
    return ~x;
  endfunction

  assign and_o = bit_and(a_i, b_i);
  assign or_o  = bit_or(a_i, b_i);
  assign inv_o = bit_inv(a_i);

  always_comb begin
    p_and_inside_or_r4: assert ((and_o & ~or_o) == '0)
      else $error("R4 AND result has bits outside OR result");
    p_inv_disjoint_r5: assert (((inv_o ^ a_i) == '1))
      else $error("R5 complement shares bits with operand");
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] shr_res_o,
  output logic         shr_out_o,
  output logic [W-1:0] shl_res_o,
  output logic         shl_out_o,
  output logic [W-1:0] sar_res_o,
  output logic         sar_out_o
);
  localparam int unsigned MSB = W - 1;

  // One-place shift; fill selects the bit entering the vacated end.
  function automatic logic [W:0] shift_right(input logic [W-1:0] x, input logic fill);
    return {fill, x};   // {result, out-bit} in W+1 bits
  endfunction

  function automatic logic [W:0] shift_left(input logic [W-1:0] x);
    return {x, 1'b0};   // {out-bit, result}
  endfunction

  logic [W:0] shr_w, shl_w, sar_w;

  always_comb begin
    shr_w = shift_right(a_i, 1'b0);
    sar_w = shift_right(a_i, a_i[MSB]);
    shl_w = shift_left(a_i);
  end

  assign shr_res_o = shr_w[W:1];
  assign shr_out_o = shr_w[0];
  assign sar_res_o = sar_w[W:1];
  assign sar_out_o = sar_w[0];
  assign shl_res_o = shl_w[W-1:0];
  assign shl_out_o = shl_w[W];

  always_comb begin
    p_shr_recombine_r7: assert (({1'b0, shr_res_o} * 2 + {{W{1'b0}}, shr_out_o}) == {1'b0, a_i})
      else $error("R7 right shift loses a bit");
    p_shl_double_r8: assert ({shl_out_o, shl_res_o} == ({1'b0, a_i} * 2))
      else $error("R8 left shift is not a doubling");
    p_sar_sign_r9: assert (sar_res_o[MSB] == sar_res_o[MSB-1])
      else $error("R9 arithmetic shift lost sign copy");
    p_sar_vs_shr_r9: assert (sar_res_o[MSB-1:0] == shr_res_o[MSB-1:0])
      else $error("R9 arithmetic and logical shift disagree below sign");
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]     acc_in,
  input  logic [W-1:0]     opd_in,
  input  logic [SEL_W-1:0] op_sel,
  output logic [W-1:0]     res_out,
  output logic             carry_out,
  output logic             zero_out
);
  // Unit outputs brought out as named wires for the checks below.
  logic [W-1:0] add_res, sub_res, inc_res;
  logic         add_cy, sub_bw;
  logic [W-1:0] and_res, or_res, inv_res;
  logic [W-1:0] shr_res, shl_res, sar_res;
  logic         shr_cy, shl_cy, sar_cy;
  logic         sel_valid;
  op_e          op;

  acc_alu_arith #(.W(W)) u_arith (
    .a_i(acc_in), .b_i(opd_in),
    .add_res_o(add_res), .add_cy_o(add_cy),
    .sub_res_o(sub_res), .sub_bw_o(sub_bw),
    .inc_res_o(inc_res)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .a_i(acc_in), .b_i(opd_in),
    .and_o(and_res), .or_o(or_res), .inv_o(inv_res)
  );

  acc_alu_shift #(.W(W)) u_shift (
    .a_i(acc_in),
    .shr_res_o(shr_res), .shr_out_o(shr_cy),
    .shl_res_o(shl_res), .shl_out_o(shl_cy),
    .sar_res_o(sar_res), .sar_out_o(sar_cy)
  );

  assign op        = op_e'(op_sel);
  assign sel_valid = sel_is_used(op_sel);

  always_comb begin
    res_out   = '0;
    carry_out = 1'b0;
    unique case (op)
      OP_PASS: res_out = opd_in;
      OP_ADD:  begin res_out = add_res; carry_out = add_cy; end
      OP_SUB:  begin res_out = sub_res; carry_out = sub_bw; end
      OP_AND:  res_out = and_res;
      OP_OR:   res_out = or_res;
      OP_INV:  begin res_out = inv_res; carry_out = 1'b1; end
      OP_INC:  res_out = inc_res;
      OP_SHR:  begin res_out = shr_res; carry_out = shr_cy; end
      OP_SHL:  begin res_out = shl_res; carry_out = shl_cy; end
      OP_SAR:  begin res_out = sar_res; carry_out = sar_cy; end
      default: begin res_out = '0; carry_out = 1'b0; end
    endcase
  end

  assign zero_out = ~|res_out;

  always_comb begin
    p_unused_code_r11: assert (sel_valid || (zero_out && !carry_out))
      else $error("R11 unused code gave nonzero output");
    p_inv_carry_r5: assert ((op_sel != 4'd5) || carry_out)
      else $error("R5 complement carry low");
    p_inc_nocarry_r6: assert ((op_sel != 4'd6) || !carry_out)
      else $error("R6 increment raised carry");
    p_pass_nocarry_r1: assert ((op_sel != 4'd0) || (!carry_out && res_out == opd_in))
      else $error("R1 pass-through mismatch");
    p_logic_nocarry_r4: assert (!(op_sel == 4'd3 || op_sel == 4'd4) || !carry_out)
      else $error("R4 logic op raised carry");
    p_zero_vs_bits_r10: assert (!zero_out || ($countones(res_out) == 0))
      else $error("R10 zero flag with bits set");
  end
endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  typedef struct {
    int        op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    bit        c;
    bit        z;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc_in = '0;
  logic [7:0] opd_in = '0;
  logic [3:0] op_sel = '0;
  logic [7:0] res_out;
  logic       carry_out, zero_out;

  int total = 0;
  int bad = 0;
  bit stim_done = 1'b0;
  exp_t sb_q[$];

  always #2 clk = ~clk;  // 4 ns period

  acc_alu dut_i (
    .acc_in(acc_in), .opd_in(opd_in), .op_sel(op_sel),
    .res_out(res_out), .carry_out(carry_out), .zero_out(zero_out)
  );

  function automatic string req_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R11";
    endcase
  endfunction

  // Independent integer model of the requirements.
  function automatic exp_t model(input int op, input logic [7:0] a, input logic [7:0] b);
    exp_t e;
    int ia = int'(a);
    int ib = int'(b);
    int r = 0;
    bit c = 0;
    case (op)
      0: r = ib;
      1: begin r = ia + ib; c = (r > 255); end
      2: begin r = ia - ib; c = (ib > ia); end
      3: r = ia & ib;
      4: r = ia | ib;
      5: begin r = 255 - ia; c = 1; end
      6: r = ia + 1;
      7: begin r = ia / 2; c = (ia % 2) == 1; end
      8: begin r = ia * 2; c = (ia >= 128); end
      9: begin r = ia / 2 + ((ia >= 128) ? 128 : 0); c = (ia % 2) == 1; end
      default: r = 0;
    endcase
    e.op = op; e.a = a; e.b = b;
    e.res = 8'(r & 255);
    e.c = c;
    e.z = ((r & 255) == 0);
    return e;
  endfunction

  task automatic drive(input int op, input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    #1;
    op_sel = 4'(op);
    acc_in = a;
    opd_in = b;
    sb_q.push_back(model(op, a, b));
  endtask

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (res_out !== e.res) begin
        bad++;
        $display("FAIL %s result op=%0d a=%h b=%h actual=%h expected=%h",
                 req_of(e.op), e.op, e.a, e.b, res_out, e.res);
      end
      total++;
      if (carry_out !== e.c) begin
        bad++;
        $display("FAIL %s carry op=%0d a=%h b=%h actual=%b expected=%b",
                 req_of(e.op), e.op, e.a, e.b, carry_out, e.c);
      end
      total++;
      if (zero_out !== e.z) begin  // R10 zero flag for every code
        bad++;
        $display("FAIL R10 zero op=%0d a=%h b=%h actual=%b expected=%b",
                 e.op, e.a, e.b, zero_out, e.z);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset/idle state: all inputs zero, pass code (R1)
    drive(0, 8'h00, 8'h00);
    // R1 pass-through
    drive(0, 8'hFF, 8'h5A);
    // R2 add with carry and zero together
    drive(1, 8'h80, 8'h80);
    drive(1, 8'hFF, 8'h01);
    drive(1, 8'h12, 8'h34);
    // R3 subtract, borrow corners
    drive(2, 8'h00, 8'h01);
    drive(2, 8'h40, 8'h40);
    drive(2, 8'h40, 8'h41);
    drive(2, 8'h41, 8'h40);
    // R4 logic ops
    drive(3, 8'hF0, 8'h0F);
    drive(4, 8'hF0, 8'h0F);
    drive(4, 8'h00, 8'h00);
    // R5 complement
    drive(5, 8'hFF, 8'h00);
    drive(5, 8'h00, 8'hFF);
    // R6 increment wrap keeps carry low
    drive(6, 8'hFF, 8'h00);
    drive(6, 8'h7F, 8'h00);
    // R7 logical right: zero with carry
    drive(7, 8'h01, 8'h00);
    drive(7, 8'h80, 8'h00);
    // R8 logical left: zero with carry
    drive(8, 8'h80, 8'h00);
    drive(8, 8'h41, 8'h00);
    // R9 arithmetic right keeps sign
    drive(9, 8'h81, 8'h00);
    drive(9, 8'h7E, 8'h00);
    drive(9, 8'hFF, 8'h00);
    // R11 unused codes with busy operands
    for (int k = 10; k < 16; k++) drive(k, 8'hA5, 8'h3C);
    // Pseudo-random sweep over every code
    for (int op = 0; op < 16; op++) begin
      for (int n = 0; n < 150; n++) begin
        drive(op, 8'($urandom), 8'($urandom));
      end
    end
    @(posedge clk);
    @(posedge clk);
    stim_done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (stim_done && sb_q.size() == 0);
      end
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule